// File: doc/BRIEF.md
# Crosspoint Control-Memory Write Sequencer

This block sits on the host side of an external crosspoint switch array whose control memory holds one bit per switch and cannot be read back. It takes one request at a time over a valid/ready handshake. A request either sets a single switch on or off at a row/column index, or clears every switch. It then drives the array's address, data, strobe and master-clear pins. Every minimum timing window is enforced as a whole number of system clock cycles.

Each timing minimum is given in nanoseconds and converted to cycles at the stated clock period. The conversion rounds up and never returns less than one cycle. A write drives the address and data first and waits out the address setup time. It then raises the strobe for long enough to cover both the pulse width and the data setup, lowers it, and keeps address and data unchanged for the longer of the two hold times. The sequencer also keeps a local shadow of all programmed bits. This gives the rest of the chip a view of the switch states that the array itself cannot provide.

Top module: `xpt_write_seq`

## Requirements
- R1: After `rst_n` is low, `busy`, `pin_strobe`, `pin_reset`, `pin_data`, `pin_row`, `pin_col` and `shadow` are all zero and `req_ready` is 1.
- R2: `req_ready` is 1 exactly when `busy` is 0. A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. Requests offered while busy, including clears, change neither the pins nor `shadow`.
- R3: After a write is taken, `pin_strobe` stays low for A = max(1, ceil(ADDR_SETUP_NS*1000/CLK_PERIOD_PS)) cycles, with the address already driven, before it rises.
- R4: `pin_strobe` stays high for S cycles, where S is the larger of the converted strobe width and the converted data setup time.
- R5: After `pin_strobe` falls, `busy` stays 1 and the address and data stay unchanged for H cycles, where H is the larger of the converted address hold and data hold times. `busy` then drops, so a write keeps `busy` high for exactly A+S+H cycles.
- R6: `pin_reset` stays low for the whole of every write.
- R7: A clear request (`req_clear`=1) raises `pin_reset` for R = max(1, ceil(RESET_NS*1000/CLK_PERIOD_PS)) cycles with `pin_strobe` low. `busy` is high for exactly those cycles, and `shadow` is all zero once `busy` drops.
- R8: When a write completes, `shadow` bit col*2^ROW_BITS+row takes the written on/off value. Every other bit keeps its value, and `shadow` does not change at any other time.
- R9: `pin_row`, `pin_col` and `pin_data` show the accepted write's row, column and value from the first busy cycle, and do not change while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_clear | input | 1 | 1: clear all switches; 0: write one switch |
| req_row | input | ROW_BITS | Row index of the write |
| req_col | input | COL_BITS | Column index of the write |
| req_on | input | 1 | 1 turns the switch on, 0 turns it off |
| busy | output | 1 | A write or clear sequence is in progress |
| pin_row | output | ROW_BITS | Row address pins of the array |
| pin_col | output | COL_BITS | Column address pins of the array |
| pin_data | output | 1 | Data pin of the array |
| pin_strobe | output | 1 | Strobe pin, active high |
| pin_reset | output | 1 | Master-clear pin, active high |
| shadow | output | 2^(ROW_BITS+COL_BITS) | Local copy of all programmed switch bits |

## Verification
The assertions check on every cycle the properties that hold at any time. Strobe and clear never overlap, and clear stays low through a write. Address and data hold still while busy. Each strobe and clear pulse reaches its minimum length before it falls, and the shadow moves only on a completion event. The exact cycle counts of the setup, strobe and hold windows, the bit each row/column pair maps to in the shadow, and the dropping of requests offered while busy can only be shown by the bench's scenarios. These scenarios compare each cycle against values the bench computes from the nanosecond parameters and its own model of the shadow.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ASETUP = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_CLEAR  = 3'd4
  } xpt_state_e;

  // nanoseconds to clock cycles, rounded up, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xpt_phase_timer.sv
module xpt_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/xpt_shadow_mem.sv
module xpt_shadow_mem #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ROW_BITS-1:0]                 wr_row,
  input  logic [COL_BITS-1:0]                 wr_col,
  input  logic                                wr_val,
  input  logic                                clr,
  output logic [(1<<(ROW_BITS+COL_BITS))-1:0] bits
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int COLS  = 1 << COL_BITS;
  localparam int CELLS = ROWS * COLS;

  for (genvar gc = 0; gc < COLS; gc++) begin : g_col
    for (genvar gr = 0; gr < ROWS; gr++) begin : g_row
      localparam int IDX = gc * ROWS + gr;
      logic hit;
      assign hit = wr_en && (wr_row == ROW_BITS'(gr)) && (wr_col == COL_BITS'(gc));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   bits[IDX] <= 1'b0;
        else if (clr) bits[IDX] <= 1'b0;
        else if (hit) bits[IDX] <= wr_val;
      end
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (bits == '0)); // R7

  AST_SINGLE_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> ($countones(bits ^ $past(bits)) <= 1)); // R8

endmodule

// File: rtl/xpt_write_seq.sv
module xpt_write_seq
  import xpt_pkg::*;
#(
  parameter int ROW_BITS       = 3,
  parameter int COL_BITS       = 3,
  parameter int CLK_PERIOD_PS  = 8000,
  parameter int ADDR_SETUP_NS  = 10,
  parameter int ADDR_HOLD_NS   = 10,
  parameter int DATA_SETUP_NS  = 10,
  parameter int DATA_HOLD_NS   = 10,
  parameter int STROBE_NS      = 20,
  parameter int RESET_NS       = 40
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_clear,
  input  logic [ROW_BITS-1:0]                 req_row,
  input  logic [COL_BITS-1:0]                 req_col,
  input  logic                                req_on,
  output logic                                busy,
  output logic [ROW_BITS-1:0]                 pin_row,
  output logic [COL_BITS-1:0]                 pin_col,
  output logic                                pin_data,
  output logic                                pin_strobe,
  output logic                                pin_reset,
  output logic [(1<<(ROW_BITS+COL_BITS))-1:0] shadow
);
  localparam int unsigned A_CYC = ns_to_cyc(ADDR_SETUP_NS, CLK_PERIOD_PS);
  localparam int unsigned S_CYC = max2(ns_to_cyc(STROBE_NS, CLK_PERIOD_PS),
                                       ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_PS));
  localparam int unsigned H_CYC = max2(ns_to_cyc(ADDR_HOLD_NS, CLK_PERIOD_PS),
                                       ns_to_cyc(DATA_HOLD_NS, CLK_PERIOD_PS));
  localparam int unsigned R_CYC = ns_to_cyc(RESET_NS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC = max2(max2(A_CYC, S_CYC), max2(H_CYC, R_CYC));
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam int LEN_W = CNT_W + 1;

  xpt_state_e          state, nxt;
  logic                tmr_load, tmr_expired;
  logic [CNT_W-1:0]    tmr_val;
  logic                accept, accept_write;
  logic                write_done, clear_done;
  logic [ROW_BITS-1:0] lat_row;
  logic [COL_BITS-1:0] lat_col;
  logic                lat_on;
  logic [LEN_W-1:0]    stb_len, rst_len;

  assign accept       = req_valid && (state == ST_IDLE);
  assign accept_write = accept && !req_clear;

  xpt_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  always_comb begin
    nxt        = state;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    write_done = 1'b0;
    clear_done = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (req_clear) begin nxt = ST_CLEAR;  tmr_val = CNT_W'(R_CYC - 1); end
        else           begin nxt = ST_ASETUP; tmr_val = CNT_W'(A_CYC - 1); end
      end
      ST_ASETUP: if (tmr_expired) begin
        nxt = ST_STROBE; tmr_load = 1'b1; tmr_val = CNT_W'(S_CYC - 1);
      end
      ST_STROBE: if (tmr_expired) begin
        nxt = ST_HOLD; tmr_load = 1'b1; tmr_val = CNT_W'(H_CYC - 1);
      end
      ST_HOLD: if (tmr_expired) begin
        nxt = ST_IDLE; write_done = 1'b1;
      end
      ST_CLEAR: if (tmr_expired) begin
        nxt = ST_IDLE; clear_done = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lat_row <= '0;
      lat_col <= '0;
      lat_on  <= 1'b0;
    end else begin
      state <= nxt;
      if (accept_write) begin
        lat_row <= req_row;
        lat_col <= req_col;
        lat_on  <= req_on;
      end
    end
  end

  assign busy       = (state != ST_IDLE);
  assign req_ready  = !busy;
  assign pin_row    = lat_row;
  assign pin_col    = lat_col;
  assign pin_data   = lat_on;
  assign pin_strobe = (state == ST_STROBE);
  assign pin_reset  = (state == ST_CLEAR);

  xpt_shadow_mem #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(write_done), .wr_row(lat_row), .wr_col(lat_col),
    .wr_val(lat_on), .clr(clear_done), .bits(shadow)
  );

  // pulse-length trackers for the width checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_len <= '0;
      rst_len <= '0;
    end else begin
      stb_len <= pin_strobe ? ((stb_len == '1) ? stb_len : stb_len + 1'b1) : '0;
      rst_len <= pin_reset  ? ((rst_len == '1) ? rst_len : rst_len + 1'b1) : '0;
    end
  end

  AST_STROBE_RESET_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pin_strobe |-> !pin_reset); // R6

  AST_NO_RESET_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(pin_reset)) |-> !pin_reset); // R6

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_clear) |=> (busy && !pin_strobe && !pin_reset)); // R2

  AST_SETUP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_strobe) |-> (busy && $past(busy))); // R3

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_strobe) |-> (stb_len >= LEN_W'(S_CYC))); // R4

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_strobe) |-> busy); // R5

  AST_RESET_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_reset) |-> (rst_len >= LEN_W'(R_CYC))); // R7

  AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable({pin_row, pin_col, pin_data})); // R9

  AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!write_done && !clear_done) |=> $stable(shadow)); // R8

endmodule

// File: tb/xpt_write_seq_bench.sv
`timescale 1ns/1ps
module xpt_write_seq_bench;
  localparam int RB = 3;
  localparam int CB = 3;
  localparam int PER_PS = 8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_clear = 1'b0, req_on = 1'b0;
  logic [RB-1:0] req_row = '0;
  logic [CB-1:0] req_col = '0;
  logic req_ready, busy, pin_data, pin_strobe, pin_reset;
  logic [RB-1:0] pin_row;
  logic [CB-1:0] pin_col;
  logic [63:0] shadow;
  logic [63:0] exp_sh = '0;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  xpt_write_seq u_xpt_write_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_clear(req_clear), .req_row(req_row), .req_col(req_col), .req_on(req_on),
    .busy(busy), .pin_row(pin_row), .pin_col(pin_col), .pin_data(pin_data),
    .pin_strobe(pin_strobe), .pin_reset(pin_reset), .shadow(shadow)
  );

  // cycle count for a nanosecond window: smallest n with n*period >= ns
  function automatic int cycles_for(input int ns);
    int n = 1;
    while (n * PER_PS < ns * 1000) n++;
    return n;
  endfunction

  function automatic int bigger(input int a, input int b);
    if (a >= b) return a;
    return b;
  endfunction

  int a_c, s_c, h_c, r_c;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [RB-1:0] r, input logic [CB-1:0] c, input logic v, input bit poke);
    bit strobe_ok = 1, pins_ok = 1, rst_ok = 1, busy_ok = 1;
    int total;
    total = a_c + s_c + h_c;
    @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0, "R2 ready when idle", {62'd0, req_ready, busy}, 64'h2);
    req_valid = 1'b1; req_clear = 1'b0; req_row = r; req_col = c; req_on = v;
    @(posedge clk);
    for (int i = 1; i <= total; i++) begin
      @(negedge clk);
      if (i == 1) begin
        req_valid = 1'b0;
        chk(pin_row === r && pin_col === c && pin_data === v, "R9 pins driven",
            {57'd0, pin_data, pin_col, pin_row}, {57'd0, v, c, r});
      end
      if (pin_strobe !== (i > a_c && i <= a_c + s_c)) strobe_ok = 0;
      if (pin_row !== r || pin_col !== c || pin_data !== v) pins_ok = 0;
      if (pin_reset !== 1'b0) rst_ok = 0;
      if (busy !== 1'b1 || req_ready !== 1'b0) busy_ok = 0;
      if (i == 2 && poke) begin
        req_valid = 1'b1; req_clear = $urandom_range(0, 1); req_row = ~r; req_col = ~c; req_on = ~v;
      end
      if (i == 3 && poke) req_valid = 1'b0;
    end
    chk(strobe_ok, "R3/R4 strobe timing (setup A, width S)", {63'd0, strobe_ok}, 64'd1);
    chk(pins_ok, "R5/R9 address and data held", {63'd0, pins_ok}, 64'd1);
    chk(rst_ok, "R6 reset low in write", {63'd0, rst_ok}, 64'd1);
    chk(busy_ok, "R5 busy through hold", {63'd0, busy_ok}, 64'd1);
    @(negedge clk);
    exp_sh[c * 8 + r] = v;
    chk(busy === 1'b0, "R5 busy drops after A+S+H", {63'd0, busy}, 64'd0);
    chk(shadow === exp_sh, poke ? "R2 busy request ignored / R8 shadow" : "R8 shadow update", shadow, exp_sh);
  endtask

  task automatic do_clear();
    bit ok = 1;
    @(negedge clk);
    req_valid = 1'b1; req_clear = 1'b1;
    @(posedge clk);
    for (int i = 1; i <= r_c; i++) begin
      @(negedge clk);
      if (i == 1) begin req_valid = 1'b0; req_clear = 1'b0; end
      if (pin_reset !== 1'b1 || pin_strobe !== 1'b0 || busy !== 1'b1) ok = 0;
    end
    chk(ok, "R7 clear pulse width", {63'd0, ok}, 64'd1);
    @(negedge clk);
    exp_sh = '0;
    chk(pin_reset === 1'b0 && busy === 1'b0, "R7 clear ends", {62'd0, pin_reset, busy}, 64'd0);
    chk(shadow === 64'd0, "R7 shadow cleared", shadow, 64'd0);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    a_c = cycles_for(10);
    s_c = bigger(cycles_for(20), cycles_for(10));
    h_c = bigger(cycles_for(10), cycles_for(10));
    r_c = cycles_for(40);
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && pin_strobe === 1'b0 && pin_reset === 1'b0 && pin_data === 1'b0 &&
        pin_row === '0 && pin_col === '0 && shadow === '0 && req_ready === 1'b1,
        "R1 reset state", {shadow[31:0], 24'd0, busy, pin_strobe, pin_reset, pin_data, req_ready, 3'd0},
        64'h8);
    rst_n = 1'b1;
    // directed corners
    do_write(3'd0, 3'd0, 1'b1, 1'b0);
    do_write(3'd7, 3'd7, 1'b1, 1'b0);
    do_write(3'd1, 3'd0, 1'b1, 1'b1);   // bit 1
    do_write(3'd0, 3'd1, 1'b1, 1'b0);   // bit 8
    do_write(3'd0, 3'd0, 1'b0, 1'b0);   // turn off
    do_clear();
    // random mix
    for (int k = 0; k < 60; k++) begin
      if ($urandom_range(0, 9) == 0) do_clear();
      else do_write(RB'($urandom_range(0, 7)), CB'($urandom_range(0, 7)),
                    1'($urandom_range(0, 1)), ($urandom_range(0, 2) == 0));
    end
    // back-to-back write and clear
    do_write(3'd5, 3'd2, 1'b1, 1'b1);
    do_clear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule